// File: doc/BRIEF.md
# Contrast PWM Generator

This block produces a single pulse-width-modulated output for panel contrast or backlight brightness. Software programs two registers through a small write/read port. The control register holds an enable bit, an output polarity bit and a 3-bit prescaler select. The duty register holds an 8-bit compare value. An 8-bit period counter advances on each prescaled tick of the core clock. The output is active while the counter is below the latched compare value.

A new duty value is copied into the compare stage only when the counter wraps, so a write in the middle of a period never shortens or splits a pulse. Clearing the enable bit parks the output at the inactive level that the polarity bit selects. The duty register keeps its contents while the block is disabled, so enabling it again restores the same brightness.

Top module: `contrast_pwm`

## Requirements
- R1: Register port: `reg_addr`=0 selects control and `reg_addr`=1 selects duty. A write with `reg_wr` high takes effect at that clock edge. `reg_rdata` shows the selected register combinationally. The control register reads as bit 0 = enable, bit 1 = polarity, bits 4:2 = prescaler select and bits 7:5 = 0, and its written bits 7:5 are discarded.
- R2: After reset the control register reads 0x00 and the duty register reads 0xC8.
- R3: While the enable bit is 0, `pwm_out` equals the inverse of the polarity bit, and the counter and prescaler are held at zero.
- R4: Prescaler select s gives one counter tick every 2^s core cycles (ratios 1 to 128). The first tick comes 2^s cycles after the edge that sets the enable bit.
- R5: The period counter advances by one per tick from 0 to 255 and wraps to 0, so one period lasts 256 ticks.
- R6: With the polarity bit at 1, `pwm_out` is high exactly while the counter is below the compare value. A duty of 0x00 never drives it high, and 0xFF drives it high for 255 of every 256 counts.
- R7: With the polarity bit at 0, `pwm_out` is the complement of the R6 waveform.
- R8: While the block is enabled, a duty write reaches the compare stage only at the tick that wraps the counter from 255 to 0. While the block is disabled, the compare stage follows the duty register, so a period that starts at enable uses the current duty.
- R9: The duty register keeps its value through a disable. After a later enable the waveform uses that same duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
The bound checker watches the internal counting on every cycle. It checks that the disabled output sits at the polarity's inactive level and that no tick occurs while disabled. It also checks that the counter moves by exactly one per tick, holds between ticks and lands on zero after a wrap, and that the compare copy changes only at a wrap. The prescaler ratios, the exact placement of the compare edge, the inverted waveform, the deferred duty update seen at the output and the retention of the duty across a disable can only be shown by the bench's scenarios. The bench runs a cycle-accurate arithmetic model of the period over every prescaler setting and several duty values and compares the output against it.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W    = 8;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int PDIV_W   = (1 << SEL_W) - 1;
  localparam int RAT_W    = PDIV_W + 1;
  localparam logic [DATA_W-1:0] DUTY_RST = 8'hC8;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             pol;
    logic             en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // last prescaler phase before a tick: ratio 2^sel minus one
  function automatic logic [PDIV_W-1:0] last_phase(input logic [SEL_W-1:0] sel);
    logic [RAT_W-1:0] r;
    r = RAT_W'(1) << sel;
    r = r - RAT_W'(1);
    return r[PDIV_W-1:0];
  endfunction

  // output level from enable, polarity, count and compare value
  function automatic logic drive_level(input logic en, input logic pol,
                                       input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] cmp);
    logic below;
    below = (cnt < cmp);
    if (!en) return !pol;
    return pol ? below : !below;
  endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] duty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      duty <= DUTY_RST;
    end else if (wr) begin
      if (addr) duty <= wdata;
      else      ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  assign rdata = addr ? duty : DATA_W'(ctrl);
endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
  import cpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PDIV_W-1:0] phase_q;

  assign tick = en && (phase_q >= last_phase(sel));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else               phase_q <= phase_q + PDIV_W'(1);
  end
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  assign wrap = tick && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= DUTY_RST;
    end else if (!en) begin
      cnt <= '0;
      cmp <= duty;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
      if (wrap) cmp <= duty;
    end
  end
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  ctrl_t             ctrl_w;
  logic [DATA_W-1:0] duty_w;
  logic              en_w;
  logic              pol_w;
  logic              tick_w;
  logic              wrap_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  cmp_w;

  assign en_w  = ctrl_w.en;
  assign pol_w = ctrl_w.pol;

  cpwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl_w), .duty(duty_w)
  );

  cpwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_w), .sel(ctrl_w.sel), .tick(tick_w)
  );

  cpwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .duty(duty_w[CNT_W-1:0]),
    .cnt(cnt_w), .cmp(cmp_w), .wrap(wrap_w)
  );

  assign pwm_out = drive_level(en_w, pol_w, cnt_w, cmp_w);
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       pol,
  input logic       tick,
  input logic       wrap,
  input logic [7:0] cnt,
  input logic [7:0] cmp,
  input logic       pwm
);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm == !pol));

  p_no_tick_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> (!en || cnt == $past(cnt) + 8'd1));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (!en || $stable(cnt)));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (cnt == 8'd0));

  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> (!en || $stable(cmp)));
endmodule

bind contrast_pwm cpwm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_w), .pol(pol_w), .tick(tick_w),
  .wrap(wrap_w), .cnt(cnt_w), .cmp(cmp_w), .pwm(pwm_out)
);

// File: tb/contrast_pwm_test.sv
module contrast_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string cur_req = "R3";

  // reference model state
  bit       m_en = 0, m_pol = 0;
  int       m_sel = 0;
  int       m_duty = 'hC8, m_cmp = 'hC8;
  int       m_m = 0;

  contrast_pwm uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_out();
    int ratio, c;
    bit below;
    if (!m_en) return !m_pol;
    ratio = 1 << m_sel;
    c = (m_m / ratio) % 256;
    below = (c < m_cmp);
    return m_pol ? below : !below;
  endfunction

  task automatic model_edge(input bit wr, input bit addr, input logic [7:0] d);
    int ratio;
    ratio = 1 << m_sel;
    if (m_en) begin
      m_m++;
      if (m_m % (256 * ratio) == 0) m_cmp = m_duty;
    end else begin
      m_m = 0;
      m_cmp = m_duty;
    end
    if (wr) begin
      if (addr) m_duty = d;
      else begin
        m_en  = d[0];
        m_pol = d[1];
        m_sel = int'(d[4:2]);
      end
    end
  endtask

  task automatic check_out();
    bit e;
    e = exp_out();
    total++;
    if (pwm_out !== e) begin
      bad++;
      $display("FAIL %s: pwm_out=%0b expected=%0b (m=%0d sel=%0d cmp=%0h)",
               cur_req, pwm_out, e, m_m, m_sel, m_cmp);
    end
  endtask

  task automatic step(input bit wr, input bit addr, input logic [7:0] d);
    reg_wr = wr; reg_addr = addr; reg_wdata = d;
    @(posedge clk);
    model_edge(wr, addr, d);
    @(negedge clk);
    reg_wr = 1'b0;
    check_out();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic rd(input bit addr, input logic [7:0] e, input string tag);
    reg_addr = addr;
    #1;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s: rdata[%0d]=%0h expected=%0h", tag, addr, reg_rdata, e);
    end
  endtask

  initial begin
    repeat (100000 + 90000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run state=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset values, R3 inactive level with polarity 0
    rd(1'b0, 8'h00, "R2");
    rd(1'b1, 8'hC8, "R2");
    cur_req = "R3";
    check_out();
    run(4);

    // R5/R6: positive polarity, ratio 1, default duty
    cur_req = "R5/R6";
    step(1'b1, 1'b0, 8'h03);
    run(600);

    // R8: duty write mid-period takes effect only at wrap
    cur_req = "R8";
    run(100);
    step(1'b1, 1'b1, 8'h40);
    run(600);
    cur_req = "R6";
    step(1'b1, 1'b1, 8'h00);
    run(400);
    step(1'b1, 1'b1, 8'hFF);
    run(600);
    step(1'b1, 1'b1, 8'h01);
    run(400);

    // R7: inverted polarity
    cur_req = "R7";
    step(1'b1, 1'b1, 8'h90);
    step(1'b1, 1'b0, 8'h01);
    run(600);

    // R3, R9: disable keeps duty, re-enable restores it
    cur_req = "R3";
    step(1'b1, 1'b0, 8'h00);
    run(50);
    rd(1'b1, 8'h90, "R9");
    step(1'b1, 1'b0, 8'h02);
    run(20);
    rd(1'b0, 8'h02, "R1");
    cur_req = "R9";
    step(1'b1, 1'b0, 8'h03);
    run(300);

    // R1: upper control bits discarded
    cur_req = "R1";
    step(1'b1, 1'b0, 8'hFE);
    rd(1'b0, 8'h1E, "R1");
    rd(1'b1, 8'h90, "R1");
    run(5);

    // R4: every prescaler ratio over a full period
    cur_req = "R4";
    step(1'b1, 1'b1, 8'h55);
    step(1'b1, 1'b0, 8'h02);
    for (int s = 1; s < 8; s++) begin
      step(1'b1, 1'b0, 8'((s << 2) | 3));
      run(256 * (1 << s) + 40);
      step(1'b1, 1'b0, 8'h02);
      run(3);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule